// File: doc/BRIEF.md
# Serial Infrared Pulse Modulator

This block turns a stream of data bits into the short optical pulses used by slow asynchronous serial infrared links. A zero bit produces one pulse at the start of its bit period and a one bit produces none. All timing is taken from a reference tick (one clock-wide strobe at the reference rate, 8 MHz beside a 40 MHz primary clock or 16 MHz beside a 48 MHz one). A six-bit rate divisor turns reference ticks into width units. Sixteen width units make one bit period. A five-bit width code sets how many units each pulse lasts.

Software writes a 16-bit physical-layer control word into a staging register. The staging register accepts writes only while the phy enable is low. The staged word is copied into the applied register on the enable's low-to-high transition, and both registers can be read back at all times. The block requests one data bit per bit period with a one-cycle strobe, samples that bit in the same cycle, and drives a single infrared output whose polarity can be inverted.

Top module: `sir_pulse_mod`

## Requirements
- R1: The control word holds the rate divisor in bits [15:10], the width code in bits [9:5] and a preamble field in bits [4:0]. The preamble field is stored and read back but does not change the output.
- R2: A write to the staging register (`ctl_wr` high) is accepted only while `phy_en` is 0. A write made while `phy_en` is 1 leaves `nxt_ctl` unchanged.
- R3: `cur_ctl` takes the value of `nxt_ctl` on the clock edge that ends the first cycle in which `phy_en` is 1 after being 0. At no other time does `cur_ctl` change.
- R4: `bit_take` is high for one cycle in the cycle in which `phy_en` rises, and then once every 16*(divisor+1) reference ticks while `phy_en` stays 1. `bit_in` is sampled in that cycle.
- R5: For a sampled zero bit, the output is active from the cycle after the bit is taken for (width+1)*(divisor+1) reference ticks. A sampled one bit leaves the output inactive for the whole bit period.
- R6: A width code of 15 or more makes the pulse last the whole bit period. Consecutive zero bits then give one unbroken active stretch.
- R7: `ir_out` equals the active level XOR `tx_inv`. Active is 1 when `tx_inv` is 0.
- R8: While `phy_en` is 0, `ir_out` is inactive (equal to `tx_inv`) in the same cycle, and no pulse is pending when the enable returns.
- R9: In a cycle without `ref_tick`, the pulse state and the bit timing do not advance.
- R10: After reset, `nxt_ctl` and `cur_ctl` are 0, `bit_take` is 0 and `ir_out` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| phy_en | input | 1 | Phy enable; its rising edge applies the staged word |
| ctl_wr | input | 1 | Write strobe for the staging register |
| ctl_wdata | input | 16 | Control word to stage |
| tx_inv | input | 1 | Invert the infrared output |
| bit_in | input | 1 | Data bit, sampled when `bit_take` is high |
| bit_take | output | 1 | Bit request/accept strobe at each bit period start |
| ir_out | output | 1 | Infrared transmit output |
| nxt_ctl | output | 16 | Readback of the staged control word |
| cur_ctl | output | 16 | Readback of the applied control word |

## Verification
The end of a pulse and the start of the next bit period land on the same unit tick whenever the width code is 15 or larger. In that cycle the new bit's value must win over the clear. The vector table provokes this collision with width codes of exactly 15 and above 15, including runs of back-to-back zero bits, and judges the result by counting active cycles and rising edges over eight bit periods. A second overlap, a staging write arriving while the enable is high, is driven directly and judged by both readback registers.

// File: rtl/sir_pwm_pkg.sv
package sir_pwm_pkg;

  localparam int BAUD_W = 6;
  localparam int WID_W  = 5;
  localparam int PRE_W  = 5;
  localparam int CTL_W  = BAUD_W + WID_W + PRE_W;

  // field order is the register layout: divisor high, width, preamble low
  typedef struct packed {
    logic [BAUD_W-1:0] baud;
    logic [WID_W-1:0]  wid;
    logic [PRE_W-1:0]  pre;
  } phy_ctl_t;

endpackage

// File: rtl/sir_ctl_regs.sv
module sir_ctl_regs
  import sir_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     phy_en,
  input  logic     wr,
  input  phy_ctl_t wdata,
  output phy_ctl_t nxt_q,
  output phy_ctl_t cur_q,
  output logic     rise,
  output logic     run
);

  logic     en_q;
  phy_ctl_t nxt_d;
  phy_ctl_t cur_d;
  logic     nxt_ce;

  assign rise   = phy_en & ~en_q;
  assign run    = phy_en & en_q;
  assign nxt_ce = wr & ~phy_en;

  always_comb begin
    nxt_d = nxt_q;
    cur_d = cur_q;
    if (nxt_ce) nxt_d = wdata;
    if (rise)   cur_d = nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      nxt_q <= '0;
      cur_q <= '0;
    end else begin
      en_q  <= phy_en;
      nxt_q <= nxt_d;
      cur_q <= cur_d;
    end
  end

endmodule

// File: rtl/sir_unit_timer.sv
module sir_unit_timer
  import sir_pwm_pkg::*;
#(
  parameter int BIT_UNITS = 16,
  localparam int UNIT_W = (BIT_UNITS > 1) ? $clog2(BIT_UNITS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              run,
  input  logic              ref_tick,
  input  logic [BAUD_W-1:0] baud,
  output logic              unit_tick,
  output logic [UNIT_W-1:0] unit_idx,
  output logic              bit_start
);

  localparam logic [UNIT_W-1:0] LAST_UNIT = UNIT_W'(BIT_UNITS - 1);

  logic [BAUD_W-1:0] div_q, div_d;
  logic [UNIT_W-1:0] unit_d;
  logic              bit_end;

  assign unit_tick = run & ref_tick & (div_q == baud);
  assign bit_end   = unit_tick & (unit_idx == LAST_UNIT);
  assign bit_start = rise | bit_end;

  always_comb begin
    div_d  = div_q;
    unit_d = unit_idx;
    if (rise || !run) begin
      div_d  = '0;
      unit_d = '0;
    end else if (ref_tick) begin
      div_d = (div_q == baud) ? '0 : div_q + 1'b1;
      if (unit_tick) unit_d = bit_end ? '0 : unit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      unit_idx <= '0;
    end else begin
      div_q    <= div_d;
      unit_idx <= unit_d;
    end
  end

endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen
  import sir_pwm_pkg::*;
#(
  parameter int BIT_UNITS = 16,
  localparam int UNIT_W = (BIT_UNITS > 1) ? $clog2(BIT_UNITS) : 1,
  localparam int CMP_W  = (WID_W > UNIT_W) ? WID_W + 1 : UNIT_W + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_start,
  input  logic              bit_in,
  input  logic              unit_tick,
  input  logic [UNIT_W-1:0] unit_idx,
  input  logic [WID_W-1:0]  wid,
  output logic              pulse_q
);

  logic [CMP_W-1:0] wid_c, idx_c;
  logic             end_hit;
  logic             pulse_d;

  assign wid_c = CMP_W'(wid);
  assign idx_c = CMP_W'(unit_idx);
  // a width at or past the last unit never ends early: the bit boundary decides
  assign end_hit = unit_tick & (idx_c == wid_c);

  always_comb begin
    pulse_d = pulse_q;
    if (!active)        pulse_d = 1'b0;
    else if (bit_start) pulse_d = ~bit_in;
    else if (end_hit)   pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

endmodule

// File: rtl/sir_pulse_mod.sv
module sir_pulse_mod
  import sir_pwm_pkg::*;
#(
  parameter int BIT_UNITS = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             phy_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             tx_inv,
  input  logic             bit_in,
  output logic             bit_take,
  output logic             ir_out,
  output logic [CTL_W-1:0] nxt_ctl,
  output logic [CTL_W-1:0] cur_ctl
);

  localparam int UNIT_W = (BIT_UNITS > 1) ? $clog2(BIT_UNITS) : 1;

  phy_ctl_t          nxt_s, cur_s;
  logic              rise, run;
  logic              unit_tick, bit_start;
  logic [UNIT_W-1:0] unit_idx;
  logic              pulse_q;

  sir_ctl_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .phy_en(phy_en),
    .wr    (ctl_wr),
    .wdata (phy_ctl_t'(ctl_wdata)),
    .nxt_q (nxt_s),
    .cur_q (cur_s),
    .rise  (rise),
    .run   (run)
  );

  sir_unit_timer #(.BIT_UNITS(BIT_UNITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .run      (run),
    .ref_tick (ref_tick),
    .baud     (cur_s.baud),
    .unit_tick(unit_tick),
    .unit_idx (unit_idx),
    .bit_start(bit_start)
  );

  sir_pulse_gen #(.BIT_UNITS(BIT_UNITS)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (run | rise),
    .bit_start(bit_start),
    .bit_in   (bit_in),
    .unit_tick(unit_tick),
    .unit_idx (unit_idx),
    .wid      (cur_s.wid),
    .pulse_q  (pulse_q)
  );

  assign bit_take = bit_start;
  assign ir_out   = (pulse_q & phy_en) ^ tx_inv;
  assign nxt_ctl  = nxt_s;
  assign cur_ctl  = cur_s;

endmodule

// File: rtl/sir_pulse_mod_chk.sv
module sir_pulse_mod_chk
  import sir_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic             phy_en,
  input logic             tx_inv,
  input logic             bit_take,
  input logic             ir_out,
  input logic [CTL_W-1:0] nxt_ctl,
  input logic [CTL_W-1:0] cur_ctl,
  input logic             pulse_q,
  input logic             run
);

  assert_shadow_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_en |=> $stable(nxt_ctl));

  assert_apply_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_en) |=> (cur_ctl == $past(nxt_ctl)));

  assert_cur_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(phy_en) |=> $stable(cur_ctl));

  assert_take_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_take |-> phy_en);

  assert_off_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_en |-> (ir_out == tx_inv));

  assert_no_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_en |=> !pulse_q);

  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ref_tick) |=> $stable(pulse_q));

endmodule

bind sir_pulse_mod sir_pulse_mod_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_tick(ref_tick),
  .phy_en  (phy_en),
  .tx_inv  (tx_inv),
  .bit_take(bit_take),
  .ir_out  (ir_out),
  .nxt_ctl (nxt_ctl),
  .cur_ctl (cur_ctl),
  .pulse_q (pulse_q),
  .run     (run)
);

// File: tb/tb_sir_pulse_mod.sv
module tb_sir_pulse_mod;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b1;
  logic        phy_en = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic        tx_inv = 1'b0;
  logic        bit_in;
  logic        bit_take, ir_out;
  logic [15:0] nxt_ctl, cur_ctl;

  logic [7:0]  pat_r = 8'hFF;
  logic        idx_clr = 1'b1;
  int unsigned idx;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sir_pulse_mod dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .phy_en(phy_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tx_inv(tx_inv), .bit_in(bit_in),
    .bit_take(bit_take), .ir_out(ir_out), .nxt_ctl(nxt_ctl), .cur_ctl(cur_ctl)
  );

  // bit source: pattern LSB first, then ones
  always @(posedge clk) begin
    if (idx_clr)       idx <= 0;
    else if (bit_take) idx <= idx + 1;
  end
  assign bit_in = (idx < 8) ? pat_r[idx[2:0]] : 1'b1;

  // {divisor 6, width 5, preamble 5, pattern 8, inv 1, pad 7, active cycles 16, edges 16}
  localparam logic [63:0] VEC [8] = '{
    {6'd0,  5'd2,  5'd0,  8'hA6, 1'b0, 7'd0, 16'd12,  16'd4},
    {6'd2,  5'd12, 5'd3,  8'h00, 1'b1, 7'd0, 16'd312, 16'd8},
    {6'd11, 5'd0,  5'd0,  8'hFE, 1'b0, 7'd0, 16'd12,  16'd1},
    {6'd0,  5'd20, 5'd1,  8'hF1, 1'b0, 7'd0, 16'd48,  16'd1},
    {6'd1,  5'd15, 5'd0,  8'h5A, 1'b1, 7'd0, 16'd128, 16'd4},
    {6'd0,  5'd14, 5'd0,  8'h00, 1'b0, 7'd0, 16'd120, 16'd8},
    {6'd47, 5'd31, 5'd15, 8'hFF, 1'b0, 7'd0, 16'd0,   16'd0},
    {6'd63, 5'd12, 5'd0,  8'hEF, 1'b0, 7'd0, 16'd832, 16'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stage(input logic [15:0] w, input logic [7:0] pat, input logic inv);
    @(negedge clk);
    phy_en = 1'b0; idx_clr = 1'b1; tx_inv = inv; pat_r = pat;
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0; idx_clr = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [63:0] v = VEC[i];
    int b = int'(v[63:58]);
    logic [15:0] w = v[63:48];
    logic inv = v[39];
    int high = 0, edges = 0, takes = 0, len;
    logic act, prev = 1'b0;
    stage(w, v[47:40], inv);
    chk(nxt_ctl == w, "R1/R2 staged word", int'(nxt_ctl), int'(w));
    chk(ir_out == inv, "R7 idle level", int'(ir_out), int'(inv));
    phy_en = 1'b1;
    #1;
    chk(bit_take == 1'b1, "R4 take on rise", int'(bit_take), 1);
    takes = 1;
    len = 8 * 16 * (b + 1) + 8;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      act = ir_out ^ inv;
      if (k == 0) begin
        chk(act == ~v[40], "R5 first bit level", int'(act), int'(~v[40]));
        chk(cur_ctl == w, "R3 applied word", int'(cur_ctl), int'(w));
      end
      if (act) high++;
      if (act && !prev) edges++;
      prev = act;
      if (bit_take) takes++;
    end
    chk(high == int'(v[31:16]), "R5/R6 active cycles", high, int'(v[31:16]));
    chk(edges == int'(v[15:0]), "R6 pulse count", edges, int'(v[15:0]));
    chk(takes == 9, "R4 bit strobes", takes, 9);
    phy_en = 1'b0;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(ir_out == 1'b0, "R10 reset output", int'(ir_out), 0);
    chk(cur_ctl == 16'h0, "R10 reset applied", int'(cur_ctl), 0);
    chk(nxt_ctl == 16'h0, "R10 reset staged", int'(nxt_ctl), 0);
    chk(bit_take == 1'b0, "R10 reset strobe", int'(bit_take), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) run_vec(i);

    // R8: drop enable mid-pulse
    stage({6'd3, 5'd31, 5'd0}, 8'h00, 1'b0);
    phy_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(ir_out == 1'b1, "R8 pulse before drop", int'(ir_out), 1);
    phy_en = 1'b0;
    #1;
    chk(ir_out == 1'b0, "R8 same-cycle off", int'(ir_out), 0);
    @(negedge clk);
    chk(ir_out == 1'b0, "R8 stays off", int'(ir_out), 0);

    // R2/R3: write while enabled, then restage while disabled
    stage(16'h0C21, 8'hFF, 1'b0);
    phy_en = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 16'h1234;
    @(negedge clk);
    ctl_wr = 1'b0;
    @(negedge clk);
    chk(nxt_ctl == 16'h0C21, "R2 write ignored when enabled", int'(nxt_ctl), 16'h0C21);
    chk(cur_ctl == 16'h0C21, "R3 applied kept", int'(cur_ctl), 16'h0C21);
    stage(16'h1234, 8'hFF, 1'b0);
    chk(nxt_ctl == 16'h1234, "R2 write taken when disabled", int'(nxt_ctl), 16'h1234);
    chk(cur_ctl == 16'h0C21, "R3 no apply without rise", int'(cur_ctl), 16'h0C21);
    phy_en = 1'b1;
    @(negedge clk);
    chk(cur_ctl == 16'h1234, "R3 apply on rise", int'(cur_ctl), 16'h1234);
    phy_en = 1'b0;

    // R9: no reference ticks freezes the pulse and bit timing
    stage(16'h0000, 8'hFE, 1'b0);
    ref_tick = 1'b0;
    phy_en = 1'b1;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (ir_out && !bit_take) cnt++;
    end
    chk(cnt == 30, "R9 frozen without ticks", cnt, 30);
    ref_tick = 1'b1;
    @(negedge clk);
    chk(ir_out == 1'b0, "R9 resumes on tick", int'(ir_out), 0);
    phy_en = 1'b0;

    // R7: inverted idle level
    @(negedge clk);
    tx_inv = 1'b1;
    #1;
    chk(ir_out == 1'b1, "R7 inverted idle", int'(ir_out), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule